// File: doc/BRIEF.md
# One-Shot Buzzer Burst Controller

This block turns a software request into a tone burst of fixed length. A write strobe on the trigger input starts a burst. A width-select bit picks one of two lengths: a short burst of 8 periods of a 256 Hz tick (31.25 ms) or a long burst of 32 periods (125 ms). While the burst runs, a busy flag is available for software to read, and a gate output enables the separate tone generator. This block does not make the tone.

A separate stop strobe cancels a running burst at once. A new trigger during a burst restarts the count. The burst length is counted only on tick pulses, beginning with the first tick after the trigger. The real duration can therefore fall short of the nominal value by up to one tick period. The gate is also qualified by the module clock enable, so that a disabled sound path never drives the tone generator.

Top module: `bzp_oneshot`

## Requirements
- R1: After a synchronous reset, or when reset is asserted during a burst, `busy` and `gate` read 0 at the first edge with reset high.
- R2: A cycle with `trig_wr`=1 and `stop_wr`=0 makes `busy` 1 at the next clock edge.
- R3: With `width_long`=0 at the trigger, `busy` stays 1 through 7 counted ticks and drops to 0 at the edge of the 8th counted tick.
- R4: With `width_long`=1 at the trigger, `busy` stays 1 through 31 counted ticks and drops to 0 at the edge of the 32nd counted tick.
- R5: A tick that arrives in the same cycle as the trigger is not counted; counting starts with the first tick after the trigger.
- R6: A trigger during a running burst restarts the count from zero, and the full selected length follows the retrigger.
- R7: A cycle with `stop_wr`=1 makes `busy` and `gate` 0 at the next edge, regardless of the tick count.
- R8: When `stop_wr` and `trig_wr` are both 1 in the same cycle, the stop wins and the controller is ready (`busy`=0) after that edge.
- R9: After each edge, `gate` equals `busy` AND the value `clk_en` had at that edge. Whenever `clk_en` was 0, `gate` is 0.
- R10: Strobes held at 0 have no effect. Ticks while ready leave `busy` at 0, and without a tick or a stop a running burst keeps `busy` at 1.
- R11: The width is sampled at the trigger. Changing `width_long` during a burst does not change that burst's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Sound-path clock enable; when 0, the gate is forced low |
| tick_256 | input | 1 | One-cycle pulse at 256 Hz |
| trig_wr | input | 1 | Write-1 strobe that starts or restarts a burst |
| stop_wr | input | 1 | Write-1 strobe that ends a burst immediately |
| width_long | input | 1 | Burst width select: 0 = 8 ticks, 1 = 32 ticks |
| busy | output | 1 | Status: 1 while a burst runs, 0 when ready |
| gate | output | 1 | Registered enable for the tone generator |

## Verification
The bound checker checks the following on every cycle:
- a stop always clears the busy flag;
- a lone trigger always sets it;
- the gate follows busy and the enable;
- the flag never changes state without a trigger, a tick or a stop.

The exact burst lengths for both widths can only be shown by the bench's scenarios. The same holds for:
- the tick that coincides with a trigger not being counted;
- a retrigger restarting the full count;
- the width being captured at the trigger.

// File: rtl/bzp_pkg.sv
package bzp_pkg;
  typedef enum logic {
    BZP_READY = 1'b0,
    BZP_BUSY  = 1'b1
  } bzp_state_e;

  function automatic int bzp_idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/bzp_width_latch.sv
module bzp_width_latch #(
  parameter int SHORT_TICKS = 8,
  parameter int LONG_TICKS  = 32,
  parameter int CW          = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          width_long,
  output logic [CW-1:0] last_idx
);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_TICKS - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_TICKS - 1);

  generate
    if (SHORT_TICKS == LONG_TICKS) begin : g_fixed
      // Both widths identical: no storage needed
      assign last_idx = SHORT_LAST;
    end else begin : g_reg
      logic [CW-1:0] last_q;
      always_ff @(posedge clk) begin
        if (rst)
          last_q <= SHORT_LAST;
        else if (load)
          last_q <= width_long ? LONG_LAST : SHORT_LAST;
      end
      assign last_idx = last_q;
    end
  endgenerate
endmodule

// File: rtl/bzp_tick_count.sv
module bzp_tick_count #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] last_idx,
  output logic          expire
);
  logic [CW-1:0] cnt_q;

  assign expire = run & tick & ~clear & (cnt_q == last_idx);

  always_ff @(posedge clk) begin
    if (rst || clear)
      cnt_q <= '0;
    else if (run && tick)
      cnt_q <= expire ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/bzp_ctrl.sv
module bzp_ctrl
  import bzp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clk_en,
  input  logic trig_wr,
  input  logic stop_wr,
  input  logic expire,
  output logic start,
  output logic busy,
  output logic gate
);
  bzp_state_e state_q, state_d;
  logic       gate_q;

  assign start = trig_wr & ~stop_wr;

  always_comb begin
    state_d = state_q;
    if (stop_wr)
      state_d = BZP_READY;
    else if (trig_wr)
      state_d = BZP_BUSY;
    else if (expire)
      state_d = BZP_READY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= BZP_READY;
      gate_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      gate_q  <= (state_d == BZP_BUSY) & clk_en;
    end
  end

  assign busy = (state_q == BZP_BUSY);
  assign gate = gate_q;
endmodule

// File: rtl/bzp_oneshot.sv
module bzp_oneshot #(
  parameter int SHORT_TICKS = 8,
  parameter int LONG_TICKS  = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic clk_en,
  input  logic tick_256,
  input  logic trig_wr,
  input  logic stop_wr,
  input  logic width_long,
  output logic busy,
  output logic gate
);
  localparam int MAX_TICKS = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int CW        = bzp_pkg::bzp_idx_w(MAX_TICKS);

  logic          start;
  logic          expire;
  logic [CW-1:0] last_idx;

  bzp_width_latch #(
    .SHORT_TICKS(SHORT_TICKS),
    .LONG_TICKS (LONG_TICKS),
    .CW         (CW)
  ) u_width (
    .clk       (clk),
    .rst       (rst),
    .load      (start),
    .width_long(width_long),
    .last_idx  (last_idx)
  );

  bzp_tick_count #(.CW(CW)) u_count (
    .clk     (clk),
    .rst     (rst),
    .clear   (start),
    .run     (busy),
    .tick    (tick_256),
    .last_idx(last_idx),
    .expire  (expire)
  );

  bzp_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .clk_en (clk_en),
    .trig_wr(trig_wr),
    .stop_wr(stop_wr),
    .expire (expire),
    .start  (start),
    .busy   (busy),
    .gate   (gate)
  );
endmodule

// File: rtl/bzp_oneshot_chk.sv
module bzp_oneshot_chk (
  input logic clk,
  input logic rst,
  input logic clk_en,
  input logic tick_256,
  input logic trig_wr,
  input logic stop_wr,
  input logic busy,
  input logic gate
);
  // R7
  stop_clears_chk: assert property (@(posedge clk) disable iff (rst)
    stop_wr |=> (!busy && !gate));

  // R2
  trig_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (trig_wr && !stop_wr) |=> busy);

  // R9
  gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> !gate);

  // R9
  gate_follow_chk: assert property (@(posedge clk) disable iff (rst)
    clk_en |=> (gate == busy));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !trig_wr) |=> !busy);

  // R10
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !stop_wr && !tick_256) |=> busy);
endmodule

bind bzp_oneshot bzp_oneshot_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .clk_en  (clk_en),
  .tick_256(tick_256),
  .trig_wr (trig_wr),
  .stop_wr (stop_wr),
  .busy    (busy),
  .gate    (gate)
);

// File: tb/bzp_oneshot_test.sv
module bzp_oneshot_test;
  logic clk = 1'b0;
  logic rst, clk_en, tick_256, trig_wr, stop_wr, width_long;
  logic busy, gate;
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  bzp_oneshot uut (
    .clk(clk), .rst(rst), .clk_en(clk_en), .tick_256(tick_256),
    .trig_wr(trig_wr), .stop_wr(stop_wr), .width_long(width_long),
    .busy(busy), .gate(gate)
  );

  always #10 clk = ~clk;

  // Row: {trig, stop, wide, en, tick count[5:0], exp busy, exp gate}
  localparam int NROWS = 14;
  localparam logic [11:0] VEC [NROWS] = '{
    {1'b1, 1'b0, 1'b0, 1'b1, 6'd0,  1'b1, 1'b1},  // R2 start short
    {1'b0, 1'b0, 1'b0, 1'b1, 6'd7,  1'b1, 1'b1},  // R3 7 ticks busy
    {1'b0, 1'b0, 1'b0, 1'b1, 6'd1,  1'b0, 1'b0},  // R3 8th tick ends
    {1'b1, 1'b0, 1'b1, 1'b1, 6'd31, 1'b1, 1'b1},  // R4 31 ticks busy
    {1'b0, 1'b0, 1'b1, 1'b1, 6'd1,  1'b0, 1'b0},  // R4 32nd ends
    {1'b1, 1'b0, 1'b0, 1'b1, 6'd4,  1'b1, 1'b1},  // R6 partial burst
    {1'b1, 1'b0, 1'b0, 1'b1, 6'd7,  1'b1, 1'b1},  // R6 retrigger
    {1'b0, 1'b0, 1'b0, 1'b1, 6'd1,  1'b0, 1'b0},  // R6 full length after
    {1'b1, 1'b0, 1'b1, 1'b1, 6'd3,  1'b1, 1'b1},  // R4 long running
    {1'b0, 1'b1, 1'b1, 1'b1, 6'd0,  1'b0, 1'b0},  // R7 stop
    {1'b1, 1'b1, 1'b0, 1'b1, 6'd0,  1'b0, 1'b0},  // R8 stop wins
    {1'b1, 1'b0, 1'b0, 1'b0, 6'd0,  1'b1, 1'b0},  // R9 enable low
    {1'b0, 1'b0, 1'b0, 1'b1, 6'd0,  1'b1, 1'b1},  // R9 enable back
    {1'b0, 1'b1, 1'b0, 1'b1, 6'd0,  1'b0, 1'b0}   // R7 stop again
  };

  task automatic cyc(input logic tr, input logic st, input logic tk,
                     input logic wd, input logic en);
    trig_wr = tr; stop_wr = st; tick_256 = tk; width_long = wd; clk_en = en;
    @(negedge clk);
    trig_wr = 1'b0; stop_wr = 1'b0; tick_256 = 1'b0;
  endtask

  task automatic ticks(input int n, input logic wd, input logic en);
    for (int k = 0; k < n; k++) begin
      cyc(1'b0, 1'b0, 1'b1, wd, en);
      cyc(1'b0, 1'b0, 1'b0, wd, en);
    end
  endtask

  task automatic chk(input string req, input string what,
                     input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  initial begin
    rst = 1'b1; clk_en = 1'b1; tick_256 = 1'b0;
    trig_wr = 1'b0; stop_wr = 1'b0; width_long = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R1", "reset busy", busy, 1'b0);
    chk("R1", "reset gate", gate, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    for (int r = 0; r < NROWS; r++) begin
      cyc(VEC[r][11], VEC[r][10], 1'b0, VEC[r][9], VEC[r][8]);
      ticks(int'(VEC[r][7:2]), VEC[r][9], VEC[r][8]);
      chk($sformatf("row%0d", r), "busy", busy, VEC[r][1]);
      chk($sformatf("row%0d", r), "gate", gate, VEC[r][0]);
    end

    // R5: a tick coinciding with the trigger is not counted
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    ticks(7, 1'b0, 1'b1);
    chk("R5", "busy after 7 counted", busy, 1'b1);
    ticks(1, 1'b0, 1'b1);
    chk("R5", "busy after 8 counted", busy, 1'b0);

    // R11: the width is captured at the trigger
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    ticks(7, 1'b1, 1'b1);
    chk("R11", "busy mid burst", busy, 1'b1);
    ticks(1, 1'b1, 1'b1);
    chk("R11", "short length kept", busy, 1'b0);

    // R10: ticks while ready, and a burst held without ticks
    ticks(5, 1'b0, 1'b1);
    chk("R10", "idle ticks busy", busy, 1'b0);
    chk("R10", "idle ticks gate", gate, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 30; k++) cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10", "held without ticks", busy, 1'b1);

    // R1: reset during a burst
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "reset mid burst busy", busy, 1'b0);
    chk("R1", "reset mid burst gate", gate, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule